// File: doc/BRIEF.md
# Memory Pattern Fill Engine

This block owns a small data memory and can fill it with a fixed test pattern without host help. While the fill enable is low, the memory behaves as an ordinary memory. A host writes it through a write request channel and reads it through a read request channel; read data comes back one cycle after the request is accepted. When the fill enable goes high, the engine takes over the memory write port. It walks the address from 0 up to the top location, one write per clock, and writes a byte chosen by a 2-bit pattern select. Two of the patterns are alternating checkerboards. The other two are derived from the address.

After the top location has been written, a sticky done flag rises. While done is set, neither the engine nor the host can write the memory. The host can still read, so it can check the contents. Done stays set until the host pulses the clear input. If enable is still high at that point, a new fill starts from address 0. If enable is low, the block returns to normal operation.

Both host request channels use valid/ready. A request is taken on a clock edge where valid and ready are both high. While ready is low, the host must hold its request, or it may withdraw it. The read response has no back-pressure: the read data valid output is a one-cycle pulse and must be captured in that cycle. The memory write port outputs show each write that the memory commits on the next edge, from either source.

Top module: `mem_fill_engine`

## Requirements
- R1: After reset, fill_done, mem_we and host_rd_dvalid are 0, and host_wr_ready and host_rd_ready are 1.
- R2: When fill_en is sampled high while idle, a fill write appears in the following cycle at address 0. Each later cycle carries one write at the next higher address, up to DEPTH-1.
- R3: Pattern select 2'b00 writes 8'h55 at even addresses and 8'hAA at odd addresses. Pattern select 2'b01 writes 8'hAA at even addresses and 8'h55 at odd addresses.
- R4: Pattern select 2'b10 writes the address's low 8 bits, zero-extended when the address is narrower. Pattern select 2'b11 writes the bitwise inverse of that value.
- R5: fill_done rises on the edge that commits the write to address DEPTH-1. That is DEPTH cycles after the fill's first write appears. It is 0 throughout the fill.
- R6: While fill_done is 1, mem_we stays 0 and host_wr_ready is 0, so host writes do not reach the memory. host_rd_ready is 1, and reads return stored data one cycle after acceptance.
- R7: fill_done stays 1 until done_clr is sampled high, whatever the value of fill_en.
- R8: done_clr sampled high while fill_done is set clears it on that edge. If fill_en is 1, a new fill starts, writing address 0 in the next cycle. If fill_en is 0, the block returns to idle with both ready outputs 1.
- R9: During a fill, host_wr_ready and host_rd_ready are 0. Host write and read requests are ignored: no host write reaches the memory, and host_rd_dvalid stays 0.
- R10: If fill_en is low in a fill cycle, no write is issued in that cycle. The block returns to idle on that edge with fill_done still 0.
- R11: While idle, an accepted host write reaches the memory write port in the same cycle. An accepted host read pulses host_rd_dvalid in the next cycle, with the stored byte on host_rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fill_en | input | 1 | Fill enable |
| pat_sel | input | 2 | Fill pattern select |
| done_clr | input | 1 | Host clear of the done flag |
| fill_done | output | 1 | Sticky fill complete flag |
| host_wr_valid | input | 1 | Host write request valid |
| host_wr_ready | output | 1 | Host write request accepted when high |
| host_wr_addr | input | $clog2(DEPTH) | Host write address |
| host_wr_data | input | 8 | Host write data |
| host_rd_valid | input | 1 | Host read request valid |
| host_rd_ready | output | 1 | Host read request accepted when high |
| host_rd_addr | input | $clog2(DEPTH) | Host read address |
| host_rd_data | output | 8 | Read response data |
| host_rd_dvalid | output | 1 | Read response valid pulse |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | $clog2(DEPTH) | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The bench builds the block with DEPTH = 24. This is not a power of two, so reaching the top address cannot be confused with the counter wrapping past its all-ones value. With 24 locations, every address of every fill can be checked. All four patterns are checked both at the write port and on read-back, and restarts through the clear input stay within a few hundred cycles. Because the address is narrower than 8 bits, the address-derived patterns also exercise zero extension.

// File: rtl/mfe_pkg.sv
package mfe_pkg;

  localparam int unsigned PAT_W = 8;

  localparam logic [PAT_W-1:0] CHK_EVEN0 = 8'h55;
  localparam logic [PAT_W-1:0] CHK_ODD0  = 8'hAA;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } fill_state_e;

  typedef enum logic [1:0] {
    PAT_CHECK0 = 2'b00,
    PAT_CHECK1 = 2'b01,
    PAT_ADDR   = 2'b10,
    PAT_NADDR  = 2'b11
  } pat_sel_e;

endpackage

// File: rtl/mfe_sequencer.sv
module mfe_sequencer
  import mfe_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_en,
  input  logic          done_clr,
  output fill_state_e   state,
  output logic          fill_we,
  output logic [AW-1:0] fill_addr,
  output logic          fill_done
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  fill_state_e   state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          at_last;

  assign at_last = (addr_q == LAST_ADDR);
  assign fill_we = (state_q == ST_FILL) && fill_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (fill_en) state_d = ST_FILL;
      ST_FILL: begin
        if (!fill_en)     state_d = ST_IDLE;
        else if (at_last) state_d = ST_DONE;
      end
      ST_DONE: if (done_clr) state_d = fill_en ? ST_FILL : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (state_q != ST_FILL)      addr_d = '0;
    else if (fill_we && !at_last) addr_d = addr_q + 1'b1;
    else                          addr_d = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  assign state     = state_q;
  assign fill_addr = addr_q;
  assign fill_done = (state_q == ST_DONE);

endmodule

// File: rtl/mfe_pattern_gen.sv
module mfe_pattern_gen
  import mfe_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [1:0]       pat_sel,
  input  logic [AW-1:0]    addr,
  output logic [PAT_W-1:0] data
);

  logic [PAT_W-1:0] addr_byte;

  generate
    if (AW >= PAT_W) begin : g_wide
      assign addr_byte = addr[PAT_W-1:0];
    end else begin : g_narrow
      assign addr_byte = {{(PAT_W - AW){1'b0}}, addr};
    end
  endgenerate

  always_comb begin
    unique case (pat_sel_e'(pat_sel))
      PAT_CHECK0: data = addr[0] ? CHK_ODD0  : CHK_EVEN0;
      PAT_CHECK1: data = addr[0] ? CHK_EVEN0 : CHK_ODD0;
      PAT_ADDR:   data = addr_byte;
      PAT_NADDR:  data = ~addr_byte;
      default:    data = '0;
    endcase
  end

endmodule

// File: rtl/mfe_port_arb.sv
module mfe_port_arb
  import mfe_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  fill_state_e   state,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  input  logic          host_wr_valid,
  input  logic [AW-1:0] host_wr_addr,
  input  logic [DW-1:0] host_wr_data,
  input  logic          host_rd_valid,
  output logic          host_wr_ready,
  output logic          host_rd_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_re
);

  logic host_wr_take;

  assign host_wr_ready = (state == ST_IDLE);
  assign host_rd_ready = (state != ST_FILL);
  assign host_wr_take  = host_wr_valid && host_wr_ready;
  assign mem_re        = host_rd_valid && host_rd_ready;

  always_comb begin
    if (fill_we) begin
      mem_we    = 1'b1;
      mem_waddr = fill_addr;
      mem_wdata = fill_data;
    end else begin
      mem_we    = host_wr_take;
      mem_waddr = host_wr_addr;
      mem_wdata = host_wr_data;
    end
  end

endmodule

// File: rtl/mfe_mem.sv
module mfe_mem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= re;
  end

endmodule

// File: rtl/mem_fill_engine.sv
module mem_fill_engine
  import mfe_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned DW   = PAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_en,
  input  logic [1:0]    pat_sel,
  input  logic          done_clr,
  output logic          fill_done,
  input  logic          host_wr_valid,
  output logic          host_wr_ready,
  input  logic [AW-1:0] host_wr_addr,
  input  logic [DW-1:0] host_wr_data,
  input  logic          host_rd_valid,
  output logic          host_rd_ready,
  input  logic [AW-1:0] host_rd_addr,
  output logic [DW-1:0] host_rd_data,
  output logic          host_rd_dvalid,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);

  fill_state_e   state;
  logic          fill_we;
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] fill_data;
  logic          mem_re;

  mfe_sequencer #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_en   (fill_en),
    .done_clr  (done_clr),
    .state     (state),
    .fill_we   (fill_we),
    .fill_addr (fill_addr),
    .fill_done (fill_done)
  );

  mfe_pattern_gen #(.AW(AW)) u_pat (
    .pat_sel (pat_sel),
    .addr    (fill_addr),
    .data    (fill_data)
  );

  mfe_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .state         (state),
    .fill_we       (fill_we),
    .fill_addr     (fill_addr),
    .fill_data     (fill_data),
    .host_wr_valid (host_wr_valid),
    .host_wr_addr  (host_wr_addr),
    .host_wr_data  (host_wr_data),
    .host_rd_valid (host_rd_valid),
    .host_wr_ready (host_wr_ready),
    .host_rd_ready (host_rd_ready),
    .mem_we        (mem_we),
    .mem_waddr     (mem_waddr),
    .mem_wdata     (mem_wdata),
    .mem_re        (mem_re)
  );

  mfe_mem #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (mem_we),
    .waddr  (mem_waddr),
    .wdata  (mem_wdata),
    .re     (mem_re),
    .raddr  (host_rd_addr),
    .rdata  (host_rd_data),
    .rvalid (host_rd_dvalid)
  );

endmodule

// File: rtl/mfe_checker.sv
module mfe_checker #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done_clr,
  input logic          fill_done,
  input logic          host_wr_ready,
  input logic          host_rd_valid,
  input logic          host_rd_ready,
  input logic          host_rd_dvalid,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr
);

  // R6: done locks out all writes but keeps reads open
  assert_done_lockout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> (!mem_we && !host_wr_ready && host_rd_ready));

  // R7: done holds until cleared
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done && !done_clr) |=> fill_done);

  // R5: done rises only on the edge committing the top address
  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_done) |-> ($past(mem_we) && ($past(mem_waddr) == AW'(DEPTH - 1))));

  // R2: consecutive fill writes step the address by one
  assert_fill_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !host_wr_ready && !fill_done) |=>
      (!mem_we || host_wr_ready || fill_done ||
       (mem_waddr == AW'($past(mem_waddr) + 1'b1))));

  // R9: no read response without an accepted read
  assert_no_stray_dvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd_valid && host_rd_ready) |=> !host_rd_dvalid);

  // R11: accepted read always answers next cycle
  assert_read_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_valid && host_rd_ready) |=> host_rd_dvalid);

endmodule

bind mem_fill_engine mfe_checker #(.DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .done_clr       (done_clr),
  .fill_done      (fill_done),
  .host_wr_ready  (host_wr_ready),
  .host_rd_valid  (host_rd_valid),
  .host_rd_ready  (host_rd_ready),
  .host_rd_dvalid (host_rd_dvalid),
  .mem_we         (mem_we),
  .mem_waddr      (mem_waddr)
);

// File: tb/mem_fill_engine_bench.sv
module mem_fill_engine_bench;

  localparam int DEPTH = 24;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fill_en = 1'b0;
  logic [1:0]    pat_sel = 2'b00;
  logic          done_clr = 1'b0;
  logic          fill_done;
  logic          host_wr_valid = 1'b0;
  logic          host_wr_ready;
  logic [AW-1:0] host_wr_addr = '0;
  logic [7:0]    host_wr_data = '0;
  logic          host_rd_valid = 1'b0;
  logic          host_rd_ready;
  logic [AW-1:0] host_rd_addr = '0;
  logic [7:0]    host_rd_data;
  logic          host_rd_dvalid;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  mem_fill_engine #(.DEPTH(DEPTH)) u_mem_fill_engine (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .pat_sel(pat_sel),
    .done_clr(done_clr), .fill_done(fill_done),
    .host_wr_valid(host_wr_valid), .host_wr_ready(host_wr_ready),
    .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .host_rd_valid(host_rd_valid), .host_rd_ready(host_rd_ready),
    .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
    .host_rd_dvalid(host_rd_dvalid),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pat(input int p, input int a);
    logic [7:0] lo;
    lo = 8'(a);
    case (p)
      0: return (a % 2 != 0) ? 8'hAA : 8'h55;
      1: return (a % 2 != 0) ? 8'h55 : 8'hAA;
      2: return lo;
      default: return ~lo;
    endcase
  endfunction

  // Starts a fill (from idle, or via clear when use_clr), checks every write.
  task automatic run_fill(input int p, input bit use_clr, input bit noise);
    pat_sel  = 2'(p);
    fill_en  = 1'b1;
    done_clr = use_clr;
    @(negedge clk);
    done_clr = 1'b0;
    chk(fill_done == 1'b0, use_clr ? "R8 done cleared" : "R5 done low at start", fill_done, 0);
    if (noise) begin
      host_wr_valid = 1'b1; host_wr_addr = AW'(3); host_wr_data = 8'h5A;
      host_rd_valid = 1'b1; host_rd_addr = AW'(1);
      #1;
    end
    for (int i = 0; i < DEPTH; i++) begin
      chk(mem_we == 1'b1, "R2 fill write strobe", mem_we, 1);
      chk(int'(mem_waddr) == i, "R2 fill address", mem_waddr, i);
      chk(mem_wdata == exp_pat(p, i), (p < 2) ? "R3 checker data" : "R4 address data",
          mem_wdata, exp_pat(p, i));
      chk(fill_done == 1'b0, "R5 done low during fill", fill_done, 0);
      chk(!host_wr_ready && !host_rd_ready, "R9 readys low in fill",
          {host_wr_ready, host_rd_ready}, 0);
      chk(host_rd_dvalid == 1'b0, "R9 no read response in fill", host_rd_dvalid, 0);
      if (i == DEPTH - 1) begin
        host_wr_valid = 1'b0;
        host_rd_valid = 1'b0;
      end
      @(negedge clk);
    end
    chk(fill_done == 1'b1, "R5 done after last write", fill_done, 1);
    chk(mem_we == 1'b0, "R6 no write when done", mem_we, 0);
    chk(host_rd_dvalid == 1'b0, "R9 no late read response", host_rd_dvalid, 0);
  endtask

  task automatic host_read(input int a, input logic [7:0] exp, input string tag);
    host_rd_valid = 1'b1;
    host_rd_addr  = AW'(a);
    #1;
    chk(host_rd_ready == 1'b1, tag, host_rd_ready, 1);
    @(negedge clk);
    host_rd_valid = 1'b0;
    chk(host_rd_dvalid == 1'b1, tag, host_rd_dvalid, 1);
    chk(host_rd_data == exp, tag, host_rd_data, exp);
  endtask

  task automatic host_write(input int a, input logic [7:0] d);
    host_wr_valid = 1'b1;
    host_wr_addr  = AW'(a);
    host_wr_data  = d;
    #1;
    chk(host_wr_ready && mem_we && int'(mem_waddr) == a && mem_wdata == d,
        "R11 idle host write", {mem_we, mem_waddr, mem_wdata}, {1'b1, AW'(a), d});
    @(negedge clk);
    host_wr_valid = 1'b0;
  endtask

  task automatic readback(input int p);
    for (int a = 0; a < DEPTH; a++)
      host_read(a, exp_pat(p, a), "R6 read back in done");
  endtask

  task automatic clear_to_idle;
    fill_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(fill_done == 1'b1, "R7 done sticky with enable low", fill_done, 1);
    end
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk(fill_done == 1'b0, "R8 done cleared to idle", fill_done, 0);
    chk(host_wr_ready && host_rd_ready, "R8 idle readys", {host_wr_ready, host_rd_ready}, 3);
    chk(mem_we == 1'b0, "R8 no write in idle", mem_we, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fill_done == 0 && mem_we == 0 && host_rd_dvalid == 0, "R1 reset outputs",
        {fill_done, mem_we, host_rd_dvalid}, 0);
    chk(host_wr_ready && host_rd_ready, "R1 reset readys", {host_wr_ready, host_rd_ready}, 3);

    // idle host access
    host_write(2, 8'h3C);
    host_write(5, 8'hC3);
    host_read(2, 8'h3C, "R11 idle read");
    host_read(5, 8'hC3, "R11 idle read");

    // pattern 0 from idle
    run_fill(0, 1'b0, 1'b0);
    readback(0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(fill_done == 1'b1, "R7 done sticky with enable high", fill_done, 1);
    end
    clear_to_idle();

    // pattern 1 from idle, then restarts through clear with host noise
    run_fill(1, 1'b0, 1'b0);
    readback(1);
    run_fill(2, 1'b1, 1'b1);
    host_wr_valid = 1'b1; host_wr_addr = AW'(3); host_wr_data = 8'h5A;
    #1;
    chk(!host_wr_ready && !mem_we, "R6 host write blocked in done",
        {host_wr_ready, mem_we}, 0);
    @(negedge clk);
    host_wr_valid = 1'b0;
    host_read(3, exp_pat(2, 3), "R9 host write ignored in fill");
    readback(2);
    run_fill(3, 1'b1, 1'b0);
    readback(3);
    clear_to_idle();

    // abort mid-fill
    pat_sel = 2'b00;
    fill_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      chk(int'(mem_waddr) == i && mem_we, "R2 fill before abort", mem_waddr, i);
      @(negedge clk);
    end
    fill_en = 1'b0;
    #1;
    chk(mem_we == 1'b0, "R10 no write in abort cycle", mem_we, 0);
    @(negedge clk);
    chk(fill_done == 1'b0, "R10 done low after abort", fill_done, 0);
    chk(host_wr_ready && host_rd_ready, "R10 idle after abort",
        {host_wr_ready, host_rd_ready}, 3);
    host_read(5, exp_pat(3, 5), "R10 abort cycle left location unchanged");
    host_write(7, 8'h81);
    host_read(7, 8'h81, "R11 idle read after abort");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule